// File: doc/BRIEF.md
# Receive Ring Frame Writer

This block sits between a receive MAC and a page-organised packet memory. Frames arrive one byte per accepted beat, and each beat carries a last flag. The 6-bit multicast hash index comes with the first byte. When a frame starts, the block checks whether the controller is halted and whether the ring has room for a maximum-size frame. It then holds the six destination bytes and decides, from a receive configuration byte, whether the frame is wanted.

An accepted frame is written into the circular ring one byte per cycle, starting four bytes into its base page. Frames shorter than the minimum are padded with zeros. Once the data is written, a four-byte header goes at the start of the base page. In that same cycle the block publishes the next free page and pulses the receive interrupt. Ring start, stop, boundary and current page come in as plain inputs from the surrounding register file. That register file is expected to load the published next page into its current-page register.

The memory address is 16 bits wide: page number in the upper byte, offset in the lower byte.

Top module: `rxr_frame_writer`

## Requirements
- R1: When `ctl_stopped` is high, or when the free space is below 1518 bytes, a frame is discarded at its first byte. It causes no memory write and no commit. Free space is computed with pointers in bytes (page×256): if cur < bound it is bound−cur, otherwise (stop−start)·256 − (cur−bound).
- R2: With `rx_cfg[4]` set, every frame of six or more bytes is accepted whatever its destination.
- R3: Otherwise, a destination of six 0xFF bytes is accepted only when `rx_cfg[2]` is set.
- R4: Otherwise, a destination whose first byte has bit 0 set is accepted only when `rx_cfg[3]` is set and `mcast_table[hash]` is 1. The hash is taken from `in_hash` on the first byte.
- R5: Otherwise, the destination must equal the station address to be accepted. Received byte i is compared with `station_addr[8i+7:8i]`, with byte 0 arriving first.
- R6: An accepted frame shorter than 60 bytes is extended with zero bytes to 60.
- R7: The header is written at base×256 + 0..3: status, next page, low byte of (length+4), high byte of (length+4). Length is the padded length.
- R8: The status byte is 0x01, with 0x20 added when bit 0 of the first destination byte is set. The same value appears on `rx_status` from the cycle after the commit.
- R9: next = base + ⌊(length+4+4+255)/256⌋. If next ≥ stop, (stop−start) is subtracted.
- R10: Frame bytes are written from base×256+4 upward. When the address reaches stop×256 it continues at start×256.
- R11: For each accepted frame, `cur_wr` and `rx_irq_set` pulse together for exactly one cycle, with `cur_next` carrying the next page. Neither pulses at any other time.
- R12: When `ring_cur` is at or above the end-of-memory page (0xC0), the frame is based at `ring_start` instead.
- R13: `in_ready` is high while idle, while collecting the destination, while discarding, and while streaming. It is low from the sixth destination byte until the header is written, including the commit cycle.
- R14: A frame that ends before six bytes have arrived is discarded with no write and no commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_stopped | input | 1 | Controller halted; refuse new frames |
| rx_cfg | input | 8 | Receive configuration: bit 2 broadcast, bit 3 multicast, bit 4 accept all |
| station_addr | input | 48 | Station address, byte 0 in bits 7:0 |
| mcast_table | input | 64 | Multicast filter table indexed by hash |
| ring_start | input | 8 | First page of the ring |
| ring_stop | input | 8 | Page just past the ring |
| ring_bound | input | 8 | Boundary page (oldest unread) |
| ring_cur | input | 8 | Current write page |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Final byte of the frame |
| in_hash | input | 6 | Multicast hash index, sampled on the first byte |
| in_ready | output | 1 | Block takes the byte this cycle |
| mem_we | output | 1 | Packet memory write strobe |
| mem_addr | output | 16 | Packet memory byte address |
| mem_wdata | output | 8 | Packet memory write data |
| cur_wr | output | 1 | Load `cur_next` into the current-page register |
| cur_next | output | 8 | Next free page after the committed frame |
| rx_status | output | 8 | Status of the last committed frame |
| rx_irq_set | output | 1 | Pulse that sets the receive interrupt flag |

## Verification
Two functions can fall in the same cycle. One is the commit of a frame (header write, page publish, interrupt). The other is the arrival of the first byte of the next frame, whose free-space test and base page depend on the page that commit publishes. The bench provokes this by presenting the next frame's first byte immediately after the previous frame's last byte, with no idle gap. The byte must wait through the header cycles and then be judged against the updated page. The reference model predicts every memory byte, and every page and status, from the already-advanced pointer. Any write made against the stale page shows up as an unexpected address.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

  localparam int PAGE_W    = 8;
  localparam int ADDR_W    = 16;
  localparam int DST_BYTES = 6;
  localparam int PAGE_SZ   = 256;

  localparam int CFG_BCAST_BIT   = 2;
  localparam int CFG_MCAST_BIT   = 3;
  localparam int CFG_PROMISC_BIT = 4;

  localparam logic [7:0] STATUS_OK    = 8'h01;
  localparam logic [7:0] STATUS_GROUP = 8'h20;

  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [ADDR_W-1:0] maddr_t;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DROP, S_DECIDE, S_FLUSH, S_STREAM, S_PAD, S_HDR
  } rxr_state_e;

  // Room left between the write pointer and the reader's boundary, in bytes.
  function automatic int ring_free(page_t cur, page_t bnd, page_t start, page_t stop);
    int c;
    int b;
    c = PAGE_SZ * int'(cur);
    b = PAGE_SZ * int'(bnd);
    if (c < b) return b - c;
    return PAGE_SZ * (int'(stop) - int'(start)) - (c - b);
  endfunction

  // Page following a frame that occupies span_bytes (header + data + FCS room).
  function automatic page_t next_page(page_t base, page_t start, page_t stop, int span_bytes);
    int n;
    n = int'(base) + (span_bytes + PAGE_SZ - 1) / PAGE_SZ;
    if (n >= int'(stop)) n = n - (int'(stop) - int'(start));
    return page_t'(n);
  endfunction

  // Byte address after a, folded back to the ring start at the stop page.
  function automatic maddr_t step_addr(maddr_t a, page_t start, page_t stop);
    maddr_t n;
    n = a + maddr_t'(1);
    if (n == {stop, 8'h00}) n = {start, 8'h00};
    return n;
  endfunction

endpackage

// File: rtl/rxr_space_check.sv
module rxr_space_check
  import rxr_pkg::*;
#(
  parameter int NEED_BYTES = 1518
) (
  input  logic  stopped,
  input  page_t cur,
  input  page_t bnd,
  input  page_t start,
  input  page_t stop,
  output logic  refuse
);

  logic short_room;

  assign short_room = ring_free(cur, bnd, start, stop) < NEED_BYTES;
  assign refuse     = stopped || short_room;

endmodule

// File: rtl/rxr_dest_filter.sv
module rxr_dest_filter
  import rxr_pkg::*;
(
  input  logic [8*DST_BYTES-1:0] dst,
  input  logic [8*DST_BYTES-1:0] station,
  input  logic [7:0]             cfg,
  input  logic [63:0]            table_bits,
  input  logic [5:0]             hash,
  output logic                   accept,
  output logic                   group
);

  logic [DST_BYTES-1:0] byte_eq;
  logic [DST_BYTES-1:0] byte_ones;
  logic                 is_bcast;
  logic                 hash_hit;

  generate
    for (genvar i = 0; i < DST_BYTES; i++) begin : g_cmp
      assign byte_eq[i]   = dst[8*i +: 8] == station[8*i +: 8];
      assign byte_ones[i] = &dst[8*i +: 8];
    end
  endgenerate

  assign group    = dst[0];
  assign is_bcast = &byte_ones;
  assign hash_hit = table_bits[hash];

  always_comb begin
    if (cfg[CFG_PROMISC_BIT])  accept = 1'b1;
    else if (is_bcast)         accept = cfg[CFG_BCAST_BIT];
    else if (group)            accept = cfg[CFG_MCAST_BIT] && hash_hit;
    else                       accept = &byte_eq;
  end

endmodule

// File: rtl/rxr_addr_gen.sv
module rxr_addr_gen
  import rxr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  maddr_t load_addr,
  input  logic   step,
  input  page_t  start,
  input  page_t  stop,
  output maddr_t addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)    addr <= '0;
    else if (load) addr <= load_addr;
    else if (step) addr <= step_addr(addr, start, stop);
  end

  // R10: the last byte below the stop page is followed by the ring start
  assert_step_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && addr == ({stop, 8'h00} - maddr_t'(1)))
      |=> addr == {$past(start), 8'h00});

endmodule

// File: rtl/rxr_frame_writer.sv
module rxr_frame_writer
  import rxr_pkg::*;
#(
  parameter int         MIN_FRAME = 60,
  parameter int         MAX_FRAME = 1514,
  parameter int         HDR_BYTES = 4,
  parameter int         FCS_BYTES = 4,
  parameter logic [7:0] END_PAGE  = 8'hC0,
  parameter int         LEN_W     = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctl_stopped,
  input  logic [7:0]  rx_cfg,
  input  logic [47:0] station_addr,
  input  logic [63:0] mcast_table,
  input  logic [7:0]  ring_start,
  input  logic [7:0]  ring_stop,
  input  logic [7:0]  ring_bound,
  input  logic [7:0]  ring_cur,
  input  logic        in_valid,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  input  logic [5:0]  in_hash,
  output logic        in_ready,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_wdata,
  output logic        cur_wr,
  output logic [7:0]  cur_next,
  output logic [7:0]  rx_status,
  output logic        rx_irq_set
);

  localparam int NEED_BYTES = MAX_FRAME + HDR_BYTES;
  localparam int IDX_W      = 3;
  localparam logic [IDX_W-1:0] FLUSH_LAST = IDX_W'(DST_BYTES - 1);
  localparam logic [IDX_W-1:0] HDR_LAST   = IDX_W'(HDR_BYTES - 1);

  rxr_state_e           st_q, st_d;
  page_t                base_q;
  logic [8*DST_BYTES-1:0] dst_q;
  logic [5:0]           hash_q;
  logic [LEN_W-1:0]     len_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 last_q;
  logic [7:0]           status_q;

  // named internal events
  logic   take;
  logic   frame_start;
  logic   refuse;
  logic   accept;
  logic   group;
  logic   data_we;
  logic   hdr_we;
  logic   commit;
  logic   load_data;
  page_t  base_pick;
  maddr_t data_addr;
  maddr_t hdr_addr;
  logic [15:0] total_len;
  page_t  nxt_page;
  logic [7:0] status_byte;
  logic [7:0] wbyte;

  assign base_pick   = (ring_cur >= END_PAGE) ? ring_start : ring_cur;
  assign take        = in_valid && in_ready;
  assign frame_start = (st_q == S_IDLE) && in_valid;
  assign load_data   = frame_start && !refuse;
  assign total_len   = 16'(len_q) + 16'(HDR_BYTES);
  assign nxt_page    = next_page(base_q, ring_start, ring_stop, int'(total_len) + FCS_BYTES);
  assign status_byte = STATUS_OK | (group ? STATUS_GROUP : 8'h00);
  assign hdr_addr    = {base_q, 8'h00} + maddr_t'(idx_q);

  rxr_space_check #(.NEED_BYTES(NEED_BYTES)) u_space (
    .stopped (ctl_stopped),
    .cur     (ring_cur),
    .bnd     (ring_bound),
    .start   (ring_start),
    .stop    (ring_stop),
    .refuse  (refuse)
  );

  rxr_dest_filter u_filter (
    .dst        (dst_q),
    .station    (station_addr),
    .cfg        (rx_cfg),
    .table_bits (mcast_table),
    .hash       (hash_q),
    .accept     (accept),
    .group      (group)
  );

  rxr_addr_gen u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load_data),
    .load_addr ({base_pick, 8'h00} + maddr_t'(HDR_BYTES)),
    .step      (data_we),
    .start     (ring_start),
    .stop      (ring_stop),
    .addr      (data_addr)
  );

  always_comb begin
    unique case (st_q)
      S_IDLE, S_ADDR, S_DROP, S_STREAM: in_ready = 1'b1;
      default:                          in_ready = 1'b0;
    endcase
  end

  always_comb begin
    st_d    = st_q;
    data_we = 1'b0;
    hdr_we  = 1'b0;
    commit  = 1'b0;
    wbyte   = 8'h00;
    unique case (st_q)
      S_IDLE: begin
        if (in_valid) begin
          if (in_last)     st_d = S_IDLE;
          else if (refuse) st_d = S_DROP;
          else             st_d = S_ADDR;
        end
      end
      S_DROP: begin
        if (in_valid && in_last) st_d = S_IDLE;
      end
      S_ADDR: begin
        if (in_valid) begin
          if (len_q == LEN_W'(DST_BYTES - 1)) st_d = S_DECIDE;
          else if (in_last)                   st_d = S_IDLE;
        end
      end
      S_DECIDE: begin
        if (accept)      st_d = S_FLUSH;
        else if (last_q) st_d = S_IDLE;
        else             st_d = S_DROP;
      end
      S_FLUSH: begin
        data_we = 1'b1;
        wbyte   = dst_q[8*idx_q +: 8];
        if (idx_q == FLUSH_LAST) begin
          if (!last_q)                          st_d = S_STREAM;
          else if (int'(len_q) < MIN_FRAME)     st_d = S_PAD;
          else                                  st_d = S_HDR;
        end
      end
      S_STREAM: begin
        if (in_valid) begin
          data_we = 1'b1;
          wbyte   = in_data;
          if (in_last) st_d = (int'(len_q) + 1 < MIN_FRAME) ? S_PAD : S_HDR;
        end
      end
      S_PAD: begin
        data_we = 1'b1;
        wbyte   = 8'h00;
        if (int'(len_q) + 1 >= MIN_FRAME) st_d = S_HDR;
      end
      S_HDR: begin
        hdr_we = 1'b1;
        unique case (idx_q)
          3'd0:    wbyte = status_byte;
          3'd1:    wbyte = nxt_page;
          3'd2:    wbyte = total_len[7:0];
          default: wbyte = total_len[15:8];
        endcase
        if (idx_q == HDR_LAST) begin
          commit = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      base_q   <= '0;
      dst_q    <= '0;
      hash_q   <= '0;
      len_q    <= '0;
      idx_q    <= '0;
      last_q   <= 1'b0;
      status_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == st_q && (st_q == S_FLUSH || st_q == S_HDR)) idx_q <= idx_q + IDX_W'(1);
      else                                                     idx_q <= '0;
      if (load_data) begin
        base_q     <= base_pick;
        dst_q[7:0] <= in_data;
        hash_q     <= in_hash;
        len_q      <= LEN_W'(1);
        last_q     <= 1'b0;
      end else if (st_q == S_ADDR && take) begin
        dst_q[8*len_q[2:0] +: 8] <= in_data;
        len_q  <= len_q + LEN_W'(1);
        last_q <= in_last;
      end else if (data_we && st_q != S_FLUSH) begin
        len_q <= len_q + LEN_W'(1);
      end
      if (commit) status_q <= status_byte;
    end
  end

  assign mem_we     = data_we || hdr_we;
  assign mem_addr   = hdr_we ? hdr_addr : data_addr;
  assign mem_wdata  = wbyte;
  assign cur_wr     = commit;
  assign cur_next   = nxt_page;
  assign rx_irq_set = commit;
  assign rx_status  = status_q;

  // R1: a refused first byte leads to no write in the following cycle
  assert_refuse_nowrite_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && refuse) |=> !mem_we);

  // R2: accept-all configuration always moves from the decision to the flush
  assert_promisc_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_DECIDE && rx_cfg[CFG_PROMISC_BIT]) |=> st_q == S_FLUSH);

  // R6: nothing is committed shorter than the minimum frame
  assert_commit_minlen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> int'(len_q) >= MIN_FRAME);

  // R10: frame bytes land inside the ring
  assert_data_in_ring_R10: assert property (@(posedge clk) disable iff (!rst_n)
    data_we |-> (data_addr >= {ring_start, 8'h00} && data_addr < {ring_stop, 8'h00}));

  // R13: the input is held off while committing
  assert_busy_commit_R13: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !in_ready);

endmodule

// File: tb/tb_rxr_frame_writer.sv
`timescale 1ns/1ps
module tb_rxr_frame_writer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_stopped;
  logic [7:0]  rx_cfg;
  logic [47:0] station_addr;
  logic [63:0] mcast_table;
  logic [7:0]  ring_start, ring_stop, ring_bound, ring_cur;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_last;
  logic [5:0]  in_hash;
  logic        in_ready;
  logic        mem_we;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        cur_wr;
  logic [7:0]  cur_next;
  logic [7:0]  rx_status;
  logic        rx_irq_set;

  always #2.5 clk = ~clk;

  rxr_frame_writer dut (
    .clk(clk), .rst_n(rst_n), .ctl_stopped(ctl_stopped), .rx_cfg(rx_cfg),
    .station_addr(station_addr), .mcast_table(mcast_table),
    .ring_start(ring_start), .ring_stop(ring_stop), .ring_bound(ring_bound),
    .ring_cur(ring_cur), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_hash(in_hash), .in_ready(in_ready),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .cur_wr(cur_wr), .cur_next(cur_next), .rx_status(rx_status),
    .rx_irq_set(rx_irq_set)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] exp_mem [int];
  string      exp_tag [int];
  typedef struct { logic [7:0] nxt; logic [7:0] st; } cmt_t;
  cmt_t       cq[$];
  logic [7:0] m_cur;
  string      tag = "R1";
  bit         st_pend = 0;
  logic [7:0] st_exp;

  task automatic chk(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  // per-cycle comparison against the reference model
  always @(negedge clk) begin
    int a;
    cmt_t c;
    if (rst_n && !done) begin
      if (st_pend) begin
        chk(rx_status == st_exp, "R8", "rx_status", rx_status, st_exp);
        st_pend = 0;
      end
      if (mem_we) begin
        a = int'(mem_addr);
        if (exp_mem.exists(a)) begin
          chk(mem_wdata == exp_mem[a], exp_tag[a], $sformatf("byte @%0h", a), mem_wdata, exp_mem[a]);
          exp_mem.delete(a);
          exp_tag.delete(a);
        end else chk(0, tag, "unexpected write address", a, -1);
      end
      if (rx_irq_set != cur_wr) chk(0, "R11", "irq and page pulse differ", rx_irq_set, cur_wr);
      if (cur_wr) begin
        if (cq.size() == 0) chk(0, "R11", "unexpected commit", cur_next, 0);
        else begin
          c = cq.pop_front();
          chk(cur_next == c.nxt, "R9", "next page", cur_next, c.nxt);
          st_pend = 1;
          st_exp  = c.st;
        end
        ring_cur = cur_next;
      end
    end
  end

  task automatic put(input int a, input logic [7:0] d, input string t);
    exp_mem[a] = d;
    exp_tag[a] = t;
  endtask

  // behavioural model of one frame: fills expected memory and commit queue
  task automatic model(input logic [7:0] fr[$], input logic [5:0] h);
    int n, c, b, avail, len, a, tot, nx, base;
    bit bc, grp, match, acc;
    logic [7:0] st;
    n = fr.size();
    c = 256 * int'(m_cur);
    b = 256 * int'(ring_bound);
    avail = (c < b) ? b - c : 256 * (int'(ring_stop) - int'(ring_start)) - (c - b);
    if (ctl_stopped || avail < 1518 || n < 6) return;
    bc = 1; match = 1;
    for (int i = 0; i < 6; i++) begin
      if (fr[i] != 8'hFF) bc = 0;
      if (fr[i] != station_addr[8*i +: 8]) match = 0;
    end
    grp = fr[0][0];
    if (rx_cfg[4])      acc = 1;
    else if (bc)        acc = rx_cfg[2];
    else if (grp)       acc = rx_cfg[3] && mcast_table[h];
    else                acc = match;
    if (!acc) return;
    len  = (n < 60) ? 60 : n;
    base = (m_cur >= 8'hC0) ? int'(ring_start) : int'(m_cur);
    a = base * 256 + 4;
    for (int i = 0; i < len; i++) begin
      if (i < n) put(a, fr[i], "R10"); else put(a, 8'h00, "R6");
      a++;
      if (a == 256 * int'(ring_stop)) a = 256 * int'(ring_start);
    end
    tot = len + 4;
    nx = base + (tot + 4 + 255) / 256;
    if (nx >= int'(ring_stop)) nx = nx - (int'(ring_stop) - int'(ring_start));
    st = grp ? 8'h21 : 8'h01;
    put(base * 256,     st,               "R8");
    put(base * 256 + 1, 8'(nx),           "R7");
    put(base * 256 + 2, 8'(tot & 255),    "R7");
    put(base * 256 + 3, 8'(tot >> 8),     "R7");
    cq.push_back('{nxt: 8'(nx), st: st});
    m_cur = 8'(nx);
  endtask

  task automatic send(input logic [7:0] fr[$], input logic [5:0] h);
    for (int i = 0; i < fr.size(); i++) begin
      in_valid = 1'b1;
      in_data  = fr[i];
      in_last  = (i == fr.size() - 1);
      in_hash  = h;
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic frame(input logic [47:0] dst, input int len, input logic [5:0] h, input string t);
    logic [7:0] fr[$];
    tag = t;
    for (int i = 0; i < len; i++) fr.push_back(i < 6 ? dst[8*i +: 8] : 8'(i * 7 + len));
    model(fr, h);
    send(fr, h);
  endtask

  task automatic drain(input string t);
    repeat (80) @(negedge clk);
    chk(exp_mem.size() == 0, t, "bytes never written", exp_mem.size(), 0);
    chk(cq.size() == 0, t, "commits missing", cq.size(), 0);
    chk(ring_cur == m_cur, t, "current page", ring_cur, m_cur);
  endtask

  task automatic set_ptr(input logic [7:0] cur, input logic [7:0] bnd);
    ring_cur   = cur;
    m_cur      = cur;
    ring_bound = bnd;
  endtask

  localparam logic [47:0] ME    = 48'h55_44_33_22_11_02;
  localparam logic [47:0] OTHER = 48'h55_44_33_22_11_04;
  localparam logic [47:0] BCAST = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] GRP   = 48'h00_00_5E_00_00_01;

  initial begin
    #900us;
    if (!done) begin
      errors++;
      $display("FAIL R13 watchdog expired actual=1 expected=0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ctl_stopped = 1'b0; rx_cfg = 8'h00;
    station_addr = ME; mcast_table = 64'h0000_0000_0000_2000;
    ring_start = 8'h46; ring_stop = 8'h80;
    set_ptr(8'h46, 8'h46);
    in_valid = 1'b0; in_data = '0; in_last = 1'b0; in_hash = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1, "R13", "ready after reset", in_ready, 1);
    chk(mem_we == 1'b0, "R11", "no write after reset", mem_we, 0);
    chk(cur_wr == 1'b0 && rx_irq_set == 1'b0, "R11", "no commit after reset", cur_wr, 0);
    chk(rx_status == 8'h00, "R8", "status after reset", rx_status, 0);

    frame(ME, 64, 6'd0, "R5");     drain("R5");
    frame(OTHER, 64, 6'd0, "R5");  drain("R5");
    frame(ME, 20, 6'd0, "R6");     drain("R6");
    frame(ME, 6, 6'd0, "R6");      drain("R6");
    frame(ME, 4, 6'd0, "R14");     drain("R14");
    frame(BCAST, 70, 6'd0, "R3");  drain("R3");
    rx_cfg = 8'h04;
    frame(BCAST, 70, 6'd0, "R3");  drain("R3");
    rx_cfg = 8'h08;
    frame(GRP, 64, 6'd13, "R4");   drain("R4");
    frame(GRP, 64, 6'd12, "R4");   drain("R4");
    rx_cfg = 8'h00;
    frame(GRP, 64, 6'd13, "R4");   drain("R4");
    rx_cfg = 8'h10;
    frame(OTHER, 90, 6'd0, "R2");  drain("R2");
    rx_cfg = 8'h00;

    // back-to-back: next frame's first byte meets the commit
    frame(ME, 61, 6'd0, "R13");
    frame(ME, 300, 6'd0, "R11");
    frame(ME, 60, 6'd0, "R11");
    drain("R11");

    set_ptr(8'h50, 8'h55);
    frame(ME, 64, 6'd0, "R1");     drain("R1");
    set_ptr(8'h50, 8'h57);
    frame(ME, 64, 6'd0, "R1");     drain("R1");
    ctl_stopped = 1'b1;
    frame(ME, 64, 6'd0, "R1");     drain("R1");
    ctl_stopped = 1'b0;

    set_ptr(8'h7F, 8'h50);
    frame(ME, 300, 6'd0, "R10");   drain("R9");

    set_ptr(8'hC5, 8'hD0);
    frame(ME, 64, 6'd0, "R12");    drain("R12");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule